// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a serial flash command master driven by a host through a small byte-wide register window. The host loads a one-byte command code into a dedicated register and packs the outgoing and incoming payload lengths into a count register. It queues the outgoing payload bytes into an eight-entry byte FIFO through a single data port, then sets a start bit. The engine lowers chip select and shifts out the command code, then the queued payload bytes. It then clocks in the requested number of response bytes and releases chip select. Multi-step flash sequences such as write enabling and status polling are left to host software.

The FIFO is shared by both directions. The engine fetches outgoing bytes at the FIFO pointer and writes each received byte into the next slot, so after a transaction the FIFO holds the sent payload followed by the response. The host clears the pointer, skips the sent entries and reads the response through the same data port. The pointer value can be read back at any time.

The sequencer has six states. S_IDLE goes to S_SETUP on a start. S_SETUP goes to S_OPCODE after one serial clock period. S_OPCODE and S_WRITE each go to S_WRITE while payload bytes remain, otherwise to S_READ if a response is requested, otherwise to S_HOLD. S_READ stays in S_READ until the last response byte, then goes to S_HOLD. S_HOLD goes back to S_IDLE after one serial clock period, and chip select is released in the same cycle.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, spi_mosi is 0, the control byte (address 0x2) reads 0x00 and the pointer byte (address 0xD) reads 0x00.
- R2: Address 0x0 holds the command code and address 0x1 holds the counts: bits 7:4 give the response byte count and bits 3:0 the outgoing payload byte count. Both read back as written. A count field above 8 is treated as 8.
- R3: A read or write of address 0xC reaches the FIFO slot at the pointer and then advances the pointer by one, modulo 8. Address 0xD returns the pointer in bits 2:0 with zeros above.
- R4: Writing a 1 to bit 4 of address 0x2 sets the pointer to 0. Bit 4 always reads back as 0.
- R5: Writing a 1 to bit 0 of address 0x2 starts a transaction. Bit 0 reads 1 while the transaction is in progress and returns to 0 by itself when it ends.
- R6: In a transaction, spi_cs_n is low, and spi_sck idles low and is high only while spi_cs_n is low. spi_mosi changes after falling edges and is sampled on rising edges, most significant bit first. The command code goes out first, followed by the payload bytes read from the FIFO starting at the pointer.
- R7: In the response phase spi_mosi is 0. Each response byte, taken from spi_miso on rising edges with the most significant bit first, is written to the slot at the pointer, which is one past the last byte sent, and the pointer advances modulo 8. Any slot not written keeps its contents.
- R8: A payload count of 0 sends only the command code. A response count of 0 ends the transaction after the last sent byte. The number of serial clock pulses per transaction is 8 times (1 + payload count + response count).
- R9: The spi_sck period is DIV system clock cycles. From the fall of spi_cs_n to the first rising edge there are at least DIV cycles, and from the last falling edge to the rise of spi_cs_n there are at least DIV cycles.
- R10: While a transaction is in progress, host writes to addresses 0x0, 0x1, 0x2 and 0xC have no effect, and reads of 0xC do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (advances the FIFO pointer at 0xC) |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Directed transactions cover each of the following: payload and response counts both zero, only payload bytes, only response bytes, both counts at 8 so the response wraps over the sent bytes, and count fields above 8 that must clamp. They separate the state-machine exits that skip the write or read state. Writes and reads made during a busy transaction confirm that none of them reaches the registers or the pointer. Seeded random command codes, lengths, payloads and response bytes are then compared with a bench model of the FIFO, the wire bit stream and the serial clock timing. These expose errors in bit order, slot placement and pointer wraparound.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam logic [3:0] ADR_OPCODE = 4'h0;
    localparam logic [3:0] ADR_COUNTS = 4'h1;
    localparam logic [3:0] ADR_CTRL   = 4'h2;
    localparam logic [3:0] ADR_PORT   = 4'hC;
    localparam logic [3:0] ADR_PTR    = 4'hD;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_PRST_BIT = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_OPCODE,
        S_WRITE,
        S_READ,
        S_HOLD
    } seq_state_t;

endpackage

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    input  logic       busy,
    input  logic       eng_store,
    input  logic [7:0] eng_byte,
    input  logic       eng_adv,
    output logic [7:0] op_byte,
    output logic [3:0] tx_len,
    output logic [3:0] rx_len,
    output logic       go,
    output logic [7:0] head_byte
);
    localparam int PW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] ptr;
    logic [7:0]    cnt_q;

    logic wr_ok, wr_op, wr_cnt, wr_ctrl, wr_port, rd_port, ptr_clr;

    assign wr_ok   = bus_wr && !busy;
    assign wr_op   = wr_ok && (bus_addr == ADR_OPCODE);
    assign wr_cnt  = wr_ok && (bus_addr == ADR_COUNTS);
    assign wr_ctrl = wr_ok && (bus_addr == ADR_CTRL);
    assign wr_port = wr_ok && (bus_addr == ADR_PORT);
    assign rd_port = bus_rd && !busy && (bus_addr == ADR_PORT);
    assign ptr_clr = wr_ctrl && bus_wdata[CTRL_PRST_BIT];
    assign go      = wr_ctrl && bus_wdata[CTRL_GO_BIT];

    function automatic logic [3:0] clamp_len(input logic [3:0] f);
        return (int'(f) > DEPTH) ? 4'(DEPTH) : f;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_byte <= '0;
            cnt_q   <= '0;
        end else begin
            if (wr_op)  op_byte <= bus_wdata;
            if (wr_cnt) cnt_q   <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (eng_store) begin
            mem[ptr] <= eng_byte;
        end else if (wr_port) begin
            mem[ptr] <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (busy) begin
            if (eng_adv) ptr <= ptr + 1'b1;
        end else if (ptr_clr) begin
            ptr <= '0;
        end else if (wr_port || rd_port) begin
            ptr <= ptr + 1'b1;
        end
    end

    assign tx_len    = clamp_len(cnt_q[3:0]);
    assign rx_len    = clamp_len(cnt_q[7:4]);
    assign head_byte = mem[ptr];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_OPCODE: bus_rdata = op_byte;
            ADR_COUNTS: bus_rdata = cnt_q;
            ADR_CTRL:   bus_rdata = {7'b0, busy};
            ADR_PORT:   bus_rdata = mem[ptr];
            ADR_PTR:    bus_rdata = 8'(ptr);
            default:    bus_rdata = '0;
        endcase
    end

    // R4: a pointer reset from an idle host lands as zero
    p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr == ADR_CTRL && bus_wdata[CTRL_PRST_BIT]) |=> (ptr == '0));

    // R3: an idle data-port write moves the pointer by one
    p_port_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr == ADR_PORT) |=> (ptr == PW'($past(ptr) + 1'b1)));

    // R10: the command code holds while a transaction runs
    p_busy_locks_opcode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> $stable(op_byte));

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] op_byte,
    input  logic [3:0] tx_len,
    input  logic [3:0] rx_len,
    input  logic [7:0] head_byte,
    input  logic       tick,
    output logic       busy,
    output logic       eng_store,
    output logic [7:0] eng_byte,
    output logic       eng_adv,
    output logic       cs_n,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    seq_state_t state, nxt;

    logic       cs_q, sck_q, half, miso_bit;
    logic [7:0] shreg;
    logic [2:0] bit_cnt;
    logic [3:0] tx_left, rx_left;
    logic       shifting, byte_end, load_tx;

    assign shifting = (state == S_OPCODE) || (state == S_WRITE) || (state == S_READ);
    assign byte_end = shifting && tick && sck_q && (bit_cnt == 3'd7);
    assign load_tx  = ((state == S_OPCODE) || (state == S_WRITE)) && (tx_left != 4'd0);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (go) nxt = S_SETUP;
            S_SETUP:  if (tick && half) nxt = S_OPCODE;
            S_OPCODE,
            S_WRITE:  if (byte_end) begin
                          if (tx_left != 4'd0)      nxt = S_WRITE;
                          else if (rx_left != 4'd0) nxt = S_READ;
                          else                      nxt = S_HOLD;
                      end
            S_READ:   if (byte_end) nxt = (rx_left > 4'd1) ? S_READ : S_HOLD;
            S_HOLD:   if (tick && half) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            sck_q    <= 1'b0;
            half     <= 1'b0;
            miso_bit <= 1'b0;
            shreg    <= '0;
            bit_cnt  <= '0;
            tx_left  <= '0;
            rx_left  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (go) begin
                    cs_q    <= 1'b0;
                    sck_q   <= 1'b0;
                    half    <= 1'b0;
                    bit_cnt <= '0;
                    shreg   <= op_byte;
                    tx_left <= tx_len;
                    rx_left <= rx_len;
                end
                S_SETUP: if (tick) half <= ~half;
                S_HOLD: if (tick) begin
                    half <= ~half;
                    if (half) cs_q <= 1'b1;
                end
                S_OPCODE, S_WRITE, S_READ: if (tick) begin
                    if (!sck_q) begin
                        sck_q    <= 1'b1;
                        miso_bit <= miso;
                    end else begin
                        sck_q   <= 1'b0;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt != 3'd7) begin
                            shreg <= {shreg[6:0], miso_bit};
                        end else if (load_tx) begin
                            shreg   <= head_byte;
                            tx_left <= tx_left - 1'b1;
                        end else begin
                            shreg <= '0;
                        end
                        if (state == S_READ && bit_cnt == 3'd7) rx_left <= rx_left - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign eng_store = byte_end && (state == S_READ);
    assign eng_adv   = byte_end && (load_tx || state == S_READ);
    assign eng_byte  = {shreg[6:0], miso_bit};
    assign cs_n      = cs_q;
    assign sck       = sck_q;
    assign mosi      = ((state == S_OPCODE) || (state == S_WRITE)) ? shreg[7] : 1'b0;

    // R6: the serial clock only pulses inside chip select
    p_sck_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |-> !cs_q);

    // R6: every frame opens at bit zero with the clock low
    p_frame_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_q) |-> (bit_cnt == 3'd0 && !sck_q));

    // R5: a start from the register file only arrives when idle
    p_start_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (state == S_IDLE));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
    parameter int DIV   = 4,
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic       busy, tick, go;
    logic       eng_store, eng_adv;
    logic [7:0] eng_byte, op_byte, head_byte;
    logic [3:0] tx_len, rx_len;

    spi_eng_regs #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .busy(busy), .eng_store(eng_store), .eng_byte(eng_byte), .eng_adv(eng_adv),
        .op_byte(op_byte), .tx_len(tx_len), .rx_len(rx_len),
        .go(go), .head_byte(head_byte)
    );

    spi_eng_clkdiv #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    spi_eng_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .go(go), .op_byte(op_byte), .tx_len(tx_len), .rx_len(rx_len),
        .head_byte(head_byte), .tick(tick), .busy(busy),
        .eng_store(eng_store), .eng_byte(eng_byte), .eng_adv(eng_adv),
        .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
    );

endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;

    logic       clk = 0, rst_n = 0;
    logic [3:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_rdata;
    logic       spi_cs_n, spi_sck, spi_mosi;
    logic       spi_miso = 1'b1;

    spi_cmd_engine #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, errors = 0;

    logic [7:0] tx_data [8];
    logic [7:0] resp    [8];
    logic [7:0] model   [8];
    int         s_tx = 0;

    // flash-side model
    int         idx = 0, last_bits = 0;
    logic [7:0] cap [17];
    bit         rx_mosi_bad = 0;

    function automatic logic miso_for(int k, int ntx);
        int r;
        r = k - 8 * (1 + ntx);
        if (r < 0 || r >= 64) return 1'b1;
        return resp[r / 8][7 - (r % 8)];
    endfunction

    always @(negedge spi_sck or negedge spi_cs_n) spi_miso = miso_for(idx, s_tx);

    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            last_bits = idx;
            idx = 0;
        end else begin
            if (idx == 0) rx_mosi_bad = 0;
            if (idx / 8 < 17) cap[idx / 8] = {cap[idx / 8][6:0], spi_mosi};
            if (idx >= 8 * (1 + s_tx) && spi_mosi) rx_mosi_bad = 1;
            idx++;
        end
    end

    // timing monitor
    int  cyc = 0, t_csf = 0, t_rise = 0, t_fall = 0;
    int  setup_c = 0, hold_c = 0, per_min = 0, per_max = 0;
    bit  first_rise = 0;
    logic p_cs = 1, p_sck = 0;
    always @(negedge clk) begin
        cyc++;
        if (p_cs && !spi_cs_n) begin
            t_csf = cyc; first_rise = 1; per_min = 1000; per_max = 0;
        end
        if (!p_sck && spi_sck) begin
            if (first_rise) begin setup_c = cyc - t_csf; first_rise = 0; end
            else begin
                if (cyc - t_rise < per_min) per_min = cyc - t_rise;
                if (cyc - t_rise > per_max) per_max = cyc - t_rise;
            end
            t_rise = cyc;
        end
        if (p_sck && !spi_sck) t_fall = cyc;
        if (!p_cs && spi_cs_n) hold_c = cyc - t_fall;
        p_cs = spi_cs_n; p_sck = spi_sck;
    end

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    function automatic int clampc(int v);
        return v > 8 ? 8 : v;
    endfunction

    task automatic run_txn(logic [7:0] op, int txf, int rxf, bit poke);
        logic [7:0] d;
        int tx, rx, n;
        tx = clampc(txf); rx = clampc(rxf);
        s_tx = tx;
        bus_write(4'h0, op);
        bus_write(4'h1, 8'((rxf << 4) | txf));
        bus_write(4'h2, 8'h10);
        for (int i = 0; i < tx; i++) begin
            bus_write(4'hC, tx_data[i]);
            model[i] = tx_data[i];
        end
        for (int j = 0; j < rx; j++) model[(tx + j) % 8] = resp[j];
        bus_write(4'h2, 8'h10);
        bus_write(4'h2, 8'h01);
        bus_read(4'h2, d);
        check_eq("R5 busy after start", d, 8'h01);
        if (poke) begin
            bus_write(4'h0, ~op);
            bus_write(4'h1, 8'h00);
            bus_write(4'hC, 8'hEE);
            bus_write(4'h2, 8'h11);
            bus_read(4'hC, d);
        end
        n = 0;
        do begin bus_read(4'h2, d); n++; end while (d[0] && n < 3000);
        check_eq("R5 busy clears", d, 8'h00);
        if (poke) begin
            bus_read(4'h0, d); check_eq("R10 opcode kept", d, op);
            bus_read(4'h1, d); check_eq("R10 counts kept", d, 8'((rxf << 4) | txf));
        end
        check_eq("R8 clock pulse count", last_bits, 8 * (1 + tx + rx));
        check_eq("R6 opcode on wire", cap[0], op);
        for (int i = 0; i < tx; i++) check_eq("R6 payload on wire", cap[1 + i], tx_data[i]);
        check_eq("R7 mosi low in response", rx_mosi_bad, 0);
        check_eq("R9 setup ok", setup_c >= DIV, 1);
        check_eq("R9 hold ok", hold_c >= DIV, 1);
        if (tx + rx > 0) begin
            check_eq("R9 period min", per_min, DIV);
            check_eq("R9 period max", per_max, DIV);
        end
        bus_read(4'hD, d);
        check_eq("R7 pointer after txn", d, (tx + rx) % 8);
        bus_write(4'h2, 8'h10);
        for (int i = 0; i < 8; i++) begin
            bus_read(4'hC, d);
            check_eq("R7 fifo slot", d, model[i]);
        end
        bus_read(4'hD, d);
        check_eq("R3 pointer wrapped", d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got %0h expected %0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5A17));
        for (int i = 0; i < 8; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        check_eq("R1 cs_n idle", spi_cs_n, 1);
        check_eq("R1 sck idle", spi_sck, 0);
        check_eq("R1 mosi idle", spi_mosi, 0);
        bus_read(4'h2, d); check_eq("R1 control", d, 0);
        bus_read(4'hD, d); check_eq("R1 pointer", d, 0);

        bus_write(4'h0, 8'h9F); bus_read(4'h0, d); check_eq("R2 opcode readback", d, 8'h9F);
        bus_write(4'h1, 8'h53); bus_read(4'h1, d); check_eq("R2 counts readback", d, 8'h53);

        bus_write(4'h2, 8'h10);
        bus_write(4'hC, 8'h11); bus_write(4'hC, 8'h22); model[0] = 8'h11; model[1] = 8'h22;
        bus_read(4'hD, d); check_eq("R3 pointer after writes", d, 2);
        bus_read(4'h2, d); check_eq("R4 reset bit reads zero", d, 0);
        bus_write(4'h2, 8'h10);
        bus_read(4'hD, d); check_eq("R4 pointer cleared", d, 0);
        bus_read(4'hC, d); check_eq("R3 port read slot0", d, 8'h11);
        bus_read(4'hD, d); check_eq("R3 pointer after read", d, 1);

        for (int i = 0; i < 8; i++) begin tx_data[i] = 8'(8'hA0 + i); resp[i] = 8'(8'h3C ^ (i * 17)); end
        run_txn(8'h06, 0, 0, 0);     // R8 opcode only
        run_txn(8'h02, 3, 0, 0);     // R8 no response
        run_txn(8'h9F, 0, 4, 0);     // R8 no payload
        run_txn(8'h0B, 8, 8, 0);     // R7 wrap over sent bytes
        run_txn(8'h03, 12, 15, 0);   // R2 clamp
        run_txn(8'hD8, 2, 3, 1);     // R10 busy writes ignored

        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < 8; i++) begin
                tx_data[i] = 8'($urandom);
                resp[i]    = 8'($urandom);
            end
            run_txn(8'($urandom), $urandom % 9, $urandom % 9, ($urandom % 4) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule